// File: doc/BRIEF.md
# ISA Configuration Unlock Sequencer

This block sits on the adapter side of a legacy ISA card. It decides where the card's register window lives on the I/O bus and which interrupt line the card uses. After reset the card is silent. Host software wakes it by writing a five-byte key, split across two fixed configuration ports, and then one configuration byte. The configuration byte either places a 16-byte register window at one of eight base addresses from a table, with an interrupt code, or leaves the card disabled.

The block snoops single-cycle 8-bit I/O writes. It drives an enable flag, the decoded base address, the interrupt line number and a chip-select for the window. Read data depends only on the address. A one-bit probe register at window offset 9 lets software confirm that the card is really present at the address it chose. Two parameters select the key variant and the base table.

Top module: `isa_cfg_unlock`

## Requirements
- R1: After reset the card is disabled, the key matcher is idle, `base_addr` and `irq_line` read 0, `win_cs` is low, and reads return 0xFF.
- R2: A write of key byte 0 to port 0x779, then key bytes 1 to 4 to port 0x379, arms the block. The next write to 0x379 is latched as the configuration byte, and the outputs reflect it after that clock edge. With KEY_SEL=0 the key is 0x59,0xB9,0xC5,0xAE,0xA6. With KEY_SEL=1 it is 0x0F,0x22,0xF0,0x20,0x80.
- R3: While the block is still matching the key, a 0x379 write with the wrong byte returns the matcher to idle. A 0x779 write of anything but key byte 0 also returns it to idle. A 0x379 write while the matcher is idle changes nothing.
- R4: A 0x779 write of key byte 0 at any stage restarts matching from the second key byte.
- R5: In the configuration byte, bit 7 is the enable, bits 2:0 are the table index and bits 6:4 are the interrupt field. Bit 3 is ignored. While the card is disabled, `base_addr` and `irq_line` are 0.
- R6: With TABLE_SEL=0, indices 0 to 7 give 0x280, 0x290, 0x300, 0x310, 0x330, 0x340, 0x348 and 0x350. With TABLE_SEL=1 they give 0x220, 0x240, 0x280, 0x2A0, 0x2C0, 0x300, 0x320 and 0x340.
- R7: `irq_line` equals the interrupt field, except that field value 2 reports line 9.
- R8: `win_cs` is high exactly when the card is enabled and `base_addr <= io_addr <= base_addr+15`. It follows `io_addr` in the same cycle.
- R9: `io_rdata` is 0xFF everywhere except window offset 9 of an enabled card, where it returns the probe register.
- R10: A write to window offset 9 stores data bit 7 in the probe register. The register reads back as {bit,7'b0}, so a write of 0xC0 reads 0x80. Latching any configuration byte clears it.
- R11: Writes outside the window leave the probe register unchanged. A configuration byte of 0x00 disables the card, and its old window stops responding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Single-cycle I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| card_en | output | 1 | Card enabled by the latched configuration |
| base_addr | output | 16 | Decoded window base, 0 when disabled |
| irq_line | output | 4 | Selected interrupt line, 0 when disabled |
| win_cs | output | 1 | Address falls in the enabled 16-byte window |
| io_rdata | output | 8 | Read data for the presented address |

## Verification
The assertions assume that each write strobe lasts one clock, with address and data stable across the sampling edge. They also assume that the window never overlaps the two configuration ports, so a single write cannot both latch configuration and touch the probe register. The stimulus raises `io_wr` for exactly one edge per write and only picks table entries far from 0x379 and 0x779. Reads are pure address presentations with the strobe low, so probing cannot advance the key matcher.

// File: rtl/isa_cfg_pkg.sv
package isa_cfg_pkg;

  localparam int KEY_LEN = 5;
  localparam int STAGE_W = $clog2(KEY_LEN + 1);
  localparam int IDX_W   = 3;
  localparam int IRQF_W  = 3;

  typedef logic [15:0]        ioaddr_t;
  typedef logic [STAGE_W-1:0] stage_t;

  typedef struct packed {
    logic              en;
    logic [IRQF_W-1:0] irqf;
    logic [IDX_W-1:0]  idx;
  } cfg_t;

  // Expected byte for a key position under the chosen variant.
  function automatic logic [7:0] key_byte(input logic sel, input stage_t pos);
    logic [7:0] b;
    case (pos)
      stage_t'(0): b = sel ? 8'h0F : 8'h59;
      stage_t'(1): b = sel ? 8'h22 : 8'hB9;
      stage_t'(2): b = sel ? 8'hF0 : 8'hC5;
      stage_t'(3): b = sel ? 8'h20 : 8'hAE;
      stage_t'(4): b = sel ? 8'h80 : 8'hA6;
      default:     b = 8'h00;
    endcase
    return b;
  endfunction

  // Base address for a table index in one of the two tables.
  function automatic ioaddr_t base_lookup(input logic sel, input logic [IDX_W-1:0] idx);
    ioaddr_t a;
    if (!sel) begin
      case (idx)
        3'd0: a = 16'h0280;
        3'd1: a = 16'h0290;
        3'd2: a = 16'h0300;
        3'd3: a = 16'h0310;
        3'd4: a = 16'h0330;
        3'd5: a = 16'h0340;
        3'd6: a = 16'h0348;
        default: a = 16'h0350;
      endcase
    end else begin
      case (idx)
        3'd0: a = 16'h0220;
        3'd1: a = 16'h0240;
        3'd2: a = 16'h0280;
        3'd3: a = 16'h02A0;
        3'd4: a = 16'h02C0;
        3'd5: a = 16'h0300;
        3'd6: a = 16'h0320;
        default: a = 16'h0340;
      endcase
    end
    return a;
  endfunction

  // Interrupt field to line number: code 2 stands for line 9.
  function automatic logic [3:0] irq_map(input logic [IRQF_W-1:0] f);
    return (f == 3'd2) ? 4'd9 : {1'b0, f};
  endfunction

  // Offset of an address from a window base (wraps modulo 2^16).
  function automatic ioaddr_t win_offset(input ioaddr_t addr, input ioaddr_t base);
    return addr - base;
  endfunction

endpackage

// File: rtl/isa_key_matcher.sv
module isa_key_matcher
  import isa_cfg_pkg::*;
#(
  parameter logic    KEY_SEL  = 1'b0,
  parameter ioaddr_t KEY_PORT = 16'h0779,
  parameter ioaddr_t CFG_PORT = 16'h0379
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  ioaddr_t    addr,
  input  logic [7:0] wdata,
  output stage_t     stage,
  output logic       cfg_load
);

  localparam stage_t ARMED = stage_t'(KEY_LEN);

  stage_t stage_q, stage_n;
  logic   hit_key, hit_cfg;

  assign hit_key = wr && (addr == KEY_PORT);
  assign hit_cfg = wr && (addr == CFG_PORT);

  always_comb begin
    stage_n  = stage_q;
    cfg_load = 1'b0;
    if (hit_key) begin
      stage_n = (wdata == key_byte(KEY_SEL, stage_t'(0))) ? stage_t'(1) : stage_t'(0);
    end else if (hit_cfg) begin
      if (stage_q == ARMED) begin
        cfg_load = 1'b1;
        stage_n  = stage_t'(0);
      end else if (stage_q != stage_t'(0) && wdata == key_byte(KEY_SEL, stage_q)) begin
        stage_n = stage_t'(stage_q + 1'b1);
      end else begin
        stage_n = stage_t'(0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= stage_t'(0);
    else        stage_q <= stage_n;
  end

  assign stage = stage_q;

endmodule

// File: rtl/isa_cfg_reg.sv
module isa_cfg_reg
  import isa_cfg_pkg::*;
#(
  parameter logic TABLE_SEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  cfg_t       cfg_in,
  output cfg_t       cfg_q,
  output logic       en,
  output ioaddr_t    base,
  output logic [3:0] irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

  assign en   = cfg_q.en;
  assign base = cfg_q.en ? base_lookup(TABLE_SEL, cfg_q.idx) : '0;
  assign irq  = cfg_q.en ? irq_map(cfg_q.irqf) : 4'd0;

endmodule

// File: rtl/isa_window.sv
module isa_window
  import isa_cfg_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int PROBE_OFS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  ioaddr_t    base,
  input  logic       wr,
  input  ioaddr_t    addr,
  input  logic       wbit,
  input  logic       clr,
  output logic       cs,
  output logic       probe_sel,
  output logic [7:0] rdata
);

  localparam ioaddr_t WIN_LIM = ioaddr_t'(WIN_BYTES);
  localparam ioaddr_t PROBE   = ioaddr_t'(PROBE_OFS);

  ioaddr_t off;
  logic    probe_q;

  assign off       = win_offset(addr, base);
  assign cs        = en && (off < WIN_LIM);
  assign probe_sel = cs && (off == PROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 probe_q <= 1'b0;
    else if (clr)               probe_q <= 1'b0;
    else if (wr && probe_sel)   probe_q <= wbit;
  end

  assign rdata = probe_sel ? {probe_q, 7'b0} : 8'hFF;

endmodule

// File: rtl/isa_cfg_unlock.sv
module isa_cfg_unlock
  import isa_cfg_pkg::*;
#(
  parameter logic    KEY_SEL   = 1'b0,
  parameter logic    TABLE_SEL = 1'b0,
  parameter ioaddr_t KEY_PORT  = 16'h0779,
  parameter ioaddr_t CFG_PORT  = 16'h0379,
  parameter int      WIN_BYTES = 16,
  parameter int      PROBE_OFS = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  output logic        card_en,
  output logic [15:0] base_addr,
  output logic [3:0]  irq_line,
  output logic        win_cs,
  output logic [7:0]  io_rdata
);

  stage_t key_stage;
  logic   cfg_load;
  cfg_t   cfg_next, cfg_q;
  logic   probe_sel;

  isa_key_matcher #(
    .KEY_SEL (KEY_SEL),
    .KEY_PORT(KEY_PORT),
    .CFG_PORT(CFG_PORT)
  ) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (io_wr),
    .addr    (io_addr),
    .wdata   (io_wdata),
    .stage   (key_stage),
    .cfg_load(cfg_load)
  );

  assign cfg_next = '{en: io_wdata[7], irqf: io_wdata[6:4], idx: io_wdata[2:0]};

  isa_cfg_reg #(.TABLE_SEL(TABLE_SEL)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .cfg_in(cfg_next),
    .cfg_q (cfg_q),
    .en    (card_en),
    .base  (base_addr),
    .irq   (irq_line)
  );

  isa_window #(.WIN_BYTES(WIN_BYTES), .PROBE_OFS(PROBE_OFS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (card_en),
    .base     (base_addr),
    .wr       (io_wr),
    .addr     (io_addr),
    .wbit     (io_wdata[7]),
    .clr      (cfg_load),
    .cs       (win_cs),
    .probe_sel(probe_sel),
    .rdata    (io_rdata)
  );

endmodule

// File: rtl/isa_cfg_unlock_chk.sv
module isa_cfg_unlock_chk
  import isa_cfg_pkg::*;
#(
  parameter logic    KEY_SEL  = 1'b0,
  parameter ioaddr_t CFG_PORT = 16'h0379
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic        card_en,
  input logic        win_cs,
  input logic [7:0]  io_rdata,
  input stage_t      key_stage,
  input logic        cfg_load,
  input cfg_t        cfg_q
);

  localparam stage_t ARMED = stage_t'(KEY_LEN);

  assert_stage_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_stage <= ARMED);

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_q));

  assert_mismatch_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == CFG_PORT && key_stage != stage_t'(0) && key_stage != ARMED
     && io_wdata != key_byte(KEY_SEL, key_stage)) |=> key_stage == stage_t'(0));

  assert_cs_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_cs |-> card_en);

  assert_outside_reads_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_cs |-> io_rdata == 8'hFF);

endmodule

bind isa_cfg_unlock isa_cfg_unlock_chk #(.KEY_SEL(KEY_SEL), .CFG_PORT(CFG_PORT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_wr    (io_wr),
  .io_addr  (io_addr),
  .io_wdata (io_wdata),
  .card_en  (card_en),
  .win_cs   (win_cs),
  .io_rdata (io_rdata),
  .key_stage(key_stage),
  .cfg_load (cfg_load),
  .cfg_q    (cfg_q)
);

// File: tb/tb_isa_cfg_unlock.sv
module tb_isa_cfg_unlock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;

  logic        en_a, en_b, cs_a, cs_b;
  logic [15:0] base_a, base_b;
  logic [3:0]  irq_a, irq_b;
  logic [7:0]  rd_a, rd_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  isa_cfg_unlock dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .card_en(en_a), .base_addr(base_a), .irq_line(irq_a), .win_cs(cs_a), .io_rdata(rd_a)
  );

  isa_cfg_unlock #(.KEY_SEL(1'b1), .TABLE_SEL(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .card_en(en_b), .base_addr(base_b), .irq_line(irq_b), .win_cs(cs_b), .io_rdata(rd_b)
  );

  typedef struct {
    string       req;
    bit          alt;
    logic        en;
    logic [15:0] base;
    logic [3:0]  irq;
    logic        cs;
    logic [7:0]  rd;
  } exp_t;

  exp_t sb[$];

  // Key bytes and tables restated as arrays.
  logic [7:0]  key_a [5] = '{8'h59, 8'hB9, 8'hC5, 8'hAE, 8'hA6};
  logic [7:0]  key_b [5] = '{8'h0F, 8'h22, 8'hF0, 8'h20, 8'h80};

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    #1 io_wr = 1'b0;
  endtask

  task automatic unlock(input bit alt, input logic [7:0] cfg);
    bus_wr(16'h0779, alt ? key_b[0] : key_a[0]);
    for (int i = 1; i < 5; i++) bus_wr(16'h0379, alt ? key_b[i] : key_a[i]);
    bus_wr(16'h0379, cfg);
  endtask

  task automatic probe(input bit alt, input logic [15:0] a, input logic en,
                       input logic [15:0] base, input logic [3:0] irq,
                       input logic cs, input logic [7:0] rd, input string req);
    exp_t e;
    @(negedge clk);
    io_wr = 1'b0; io_addr = a;
    e.req = req; e.alt = alt; e.en = en; e.base = base; e.irq = irq; e.cs = cs; e.rd = rd;
    sb.push_back(e);
  endtask

  // Monitor: samples midway between the negedge and the next posedge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        exp_t e;
        logic        g_en, g_cs;
        logic [15:0] g_base;
        logic [3:0]  g_irq;
        logic [7:0]  g_rd;
        e = sb.pop_front();
        g_en   = e.alt ? en_b   : en_a;
        g_base = e.alt ? base_b : base_a;
        g_irq  = e.alt ? irq_b  : irq_a;
        g_cs   = e.alt ? cs_b   : cs_a;
        g_rd   = e.alt ? rd_b   : rd_a;
        checks++;
        if (g_en !== e.en || g_base !== e.base || g_irq !== e.irq ||
            g_cs !== e.cs || g_rd !== e.rd) begin
          failures++;
          $display("FAIL %s addr=%h actual en=%b base=%h irq=%0d cs=%b rd=%h expected en=%b base=%h irq=%0d cs=%b rd=%h",
                   e.req, io_addr, g_en, g_base, g_irq, g_cs, g_rd,
                   e.en, e.base, e.irq, e.cs, e.rd);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on both variants
    probe(0, 16'h0280, 0, 16'h0000, 0, 0, 8'hFF, "R1 reset dut");
    probe(1, 16'h0280, 0, 16'h0000, 0, 0, 8'hFF, "R1 reset alt");

    // R2 R5 R6 R7: key A, cfg 0xD3 -> idx3 (0x310), irq 5
    unlock(0, 8'hD3);
    probe(0, 16'h0310, 1, 16'h0310, 5, 1, 8'hFF, "R2 unlock first byte");
    probe(1, 16'h0310, 0, 16'h0000, 0, 0, 8'hFF, "R2 other key ignored");
    // R8: window edges
    probe(0, 16'h030F, 1, 16'h0310, 5, 0, 8'hFF, "R8 below window");
    probe(0, 16'h031F, 1, 16'h0310, 5, 1, 8'hFF, "R8 last byte");
    probe(0, 16'h0320, 1, 16'h0310, 5, 0, 8'hFF, "R8 past window");
    // R10: probe register starts clear, then stores bit 7 only
    probe(0, 16'h0319, 1, 16'h0310, 5, 1, 8'h00, "R10 probe cleared");
    bus_wr(16'h0319, 8'hC0);
    probe(0, 16'h0319, 1, 16'h0310, 5, 1, 8'h80, "R10 C0 reads 80");
    probe(0, 16'h0318, 1, 16'h0310, 5, 1, 8'hFF, "R9 other offset");
    bus_wr(16'h0319, 8'h7F);
    probe(0, 16'h0319, 1, 16'h0310, 5, 1, 8'h00, "R10 low bits dropped");
    bus_wr(16'h0319, 8'h80);
    bus_wr(16'h0329, 8'h00);
    probe(0, 16'h0319, 1, 16'h0310, 5, 1, 8'h80, "R11 outside write");

    // R4: restart mid-key, cfg 0xA6 -> idx6 (0x348), field 2 -> line 9
    bus_wr(16'h0779, 8'h59);
    bus_wr(16'h0379, 8'hB9);
    unlock(0, 8'hA6);
    probe(0, 16'h0351, 1, 16'h0348, 9, 1, 8'h00, "R4 restart / R7 irq9 / R10 clear");

    // R3: mismatched key byte drops to idle
    bus_wr(16'h0779, 8'h59);
    bus_wr(16'h0379, 8'hB9);
    bus_wr(16'h0379, 8'h00);
    bus_wr(16'h0379, 8'hC5); bus_wr(16'h0379, 8'hAE); bus_wr(16'h0379, 8'hA6);
    bus_wr(16'h0379, 8'h81);
    probe(0, 16'h0348, 1, 16'h0348, 9, 1, 8'hFF, "R3 mismatch");
    // R3: idle 0x379 writes ignored
    for (int i = 1; i < 5; i++) bus_wr(16'h0379, key_a[i]);
    bus_wr(16'h0379, 8'h87);
    probe(0, 16'h0348, 1, 16'h0348, 9, 1, 8'hFF, "R3 idle writes");
    // R3: wrong first byte
    bus_wr(16'h0779, 8'h58);
    for (int i = 1; i < 5; i++) bus_wr(16'h0379, key_a[i]);
    bus_wr(16'h0379, 8'h87);
    probe(0, 16'h0348, 1, 16'h0348, 9, 1, 8'hFF, "R3 wrong first byte");

    // R5 R6: bit 3 ignored, idx 7 -> 0x350, irq 3
    unlock(0, 8'hBF);
    probe(0, 16'h035F, 1, 16'h0350, 3, 1, 8'hFF, "R5 bit3 ignored / R6 idx7");

    // R2 R6 alt: key B, cfg 0xC2 -> table 1 idx2 (0x280), irq 4
    unlock(1, 8'hC2);
    probe(1, 16'h0289, 1, 16'h0280, 4, 1, 8'h00, "R2 alt key / R6 alt table");
    probe(0, 16'h0289, 1, 16'h0350, 3, 0, 8'hFF, "R2 dut unaffected by alt key");
    bus_wr(16'h0289, 8'hC0);
    probe(1, 16'h0289, 1, 16'h0280, 4, 1, 8'h80, "R10 alt probe");
    unlock(1, 8'h87);
    probe(1, 16'h0340, 1, 16'h0340, 0, 1, 8'hFF, "R6 alt idx7");

    // R11: disable with 0x00, window stops responding
    unlock(0, 8'h00);
    probe(0, 16'h0359, 0, 16'h0000, 0, 0, 8'hFF, "R11 disabled / R5 zero outputs");
    unlock(0, 8'h80);
    probe(0, 16'h0280, 1, 16'h0280, 0, 1, 8'hFF, "R6 idx0 re-enable");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule